// File: doc/BRIEF.md
# Power Domain Enable Sequencer

This block turns three nested power domains on and off in a fixed order. The domains are SYSTEM, POWER and POWER1. Each domain has one enable output to its regulators and one done input that reports when those regulators have settled. A request for each domain comes either from a host pin or from a register bit. A per-domain configuration input selects the source. The register bits load their start values from configuration inputs at reset.

A domain is requested only when every domain beneath it is also requested. POWER needs SYSTEM, and POWER1 needs POWER. The sequencer moves its current level one domain per step toward that target. After each step it waits for the domain's done input before it takes the next step. Power-up runs from SYSTEM toward POWER1. Power-down runs in the reverse order. During power-down, a domain whose keep-on flag is set is skipped and stays enabled.

While a step is pending, the block raises busy. A register write that arrives during that time is dropped and produces a one-cycle reject pulse. If a step waits too long, the block latches an error and stops sequencing.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, `dom_en_o`, `busy_o`, `err_o` and `rej_o` are all 0, and `reg_rdata_o` equals `cfg_init_i`.
- R2: Bit 0 is SYSTEM, bit 1 is POWER and bit 2 is POWER1 on every per-domain vector. Power-up enables bit 0, then bit 1, then bit 2. `dom_en_o` changes by at most one bit per clock. A domain is enabled only after the done input of the domain below it has been seen high.
- R3: A POWER request without a SYSTEM request leaves every enable at 0. POWER1 follows only once POWER is enabled.
- R4: When the SYSTEM request drops, the enables clear in the order bit 2, bit 1, bit 0. Each step waits until the cleared domain's done input is low.
- R5: During power-down, a domain whose `keep_on_i` bit is 1 is skipped without a wait, and its enable stays 1.
- R6: For each domain, `cfg_src_pin_i` = 1 takes the request from `pin_en_i`, and 0 takes it from the register bit. In the second case the pin has no effect. A register write accepted while idle updates `reg_rdata_o` on the next clock.
- R7: `busy_o` is 1 from the clock after a step starts until that step's done condition is met.
- R8: A write with `busy_o` = 1 leaves the register unchanged and raises `rej_o` for exactly one clock, on the following cycle.
- R9: If a step's done condition is not met within TMO_CYC (256) cycles, `err_o` sets and stays set, `busy_o` drops, and `dom_en_o` no longer changes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_init_i | input | 3 | Reset value of the request register bits |
| cfg_src_pin_i | input | 3 | Per-domain request source: 1 = pin, 0 = register |
| pin_en_i | input | 3 | Host request pins |
| keep_on_i | input | 3 | Per-domain flag: skip this domain during power-down |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | 3 | Register read-back |
| rej_o | output | 1 | One-cycle pulse for a dropped write |
| dom_done_i | input | 3 | Per-domain regulator settled |
| dom_en_o | output | 3 | Per-domain enable |
| busy_o | output | 1 | A step is pending |
| err_o | output | 1 | Sticky step timeout |

## Verification
The embedded properties assume that each done input follows its own enable after some settling delay and does not glitch while its enable is steady. The dependency checks rely on that, because they relate an enable rising to the done level of the domain below it one cycle earlier. The bench's regulator model keeps to this behaviour. It copies each enable to its done input after a fixed settling delay. For the timeout case it pins a single done input high, so it never violates the assumption in the opposite direction.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UP    = 2'd1,
    ST_DN    = 2'd2,
    ST_FAULT = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pds_enable_regs.sv
module pds_enable_regs #(
  parameter int N_DOM = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] cfg_init_i,
  input  logic [N_DOM-1:0] cfg_src_pin_i,
  input  logic [N_DOM-1:0] pin_en_i,
  input  logic             wr_i,
  input  logic [N_DOM-1:0] wdata_i,
  input  logic             busy_i,
  output logic [N_DOM-1:0] req_o,
  output logic [N_DOM-1:0] rdata_o,
  output logic             rej_o
);
  logic [N_DOM-1:0] reg_q;
  logic             rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= cfg_init_i;
      rej_q <= 1'b0;
    end else begin
      rej_q <= wr_i & busy_i;
      if (wr_i && !busy_i) reg_q <= wdata_i;
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_src
    assign req_o[d] = cfg_src_pin_i[d] ? pin_en_i[d] : reg_q[d];
  end

  assign rdata_o = reg_q;
  assign rej_o   = rej_q;

  AST_REJ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && busy_i |=> rej_o); // R8
  AST_REJ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && busy_i |=> $stable(rdata_o)); // R8
  AST_NO_REJ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && busy_i) |=> !rej_o); // R8
endmodule

// File: rtl/pds_target.sv
module pds_target #(
  parameter int N_DOM = 3,
  parameter int LVL_W = $clog2(N_DOM + 1)
) (
  input  logic [N_DOM-1:0] req_i,
  output logic [LVL_W-1:0] tgt_lvl_o
);
  logic [N_DOM-1:0] chain;

  // a domain counts only when every lower domain is requested too
  assign chain[0] = req_i[0];
  for (genvar d = 1; d < N_DOM; d++) begin : g_chain
    assign chain[d] = chain[d-1] & req_i[d];
  end

  always_comb begin
    tgt_lvl_o = '0;
    for (int d = 0; d < N_DOM; d++) begin
      if (chain[d]) tgt_lvl_o = LVL_W'(d + 1);
    end
  end
endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int TMO_CYC = 256,
  parameter int TMO_W   = $clog2(TMO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expire_o
);
  localparam logic [TMO_W-1:0] LAST = TMO_W'(TMO_CYC - 1);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/pds_step_fsm.sv
module pds_step_fsm
  import pds_pkg::*;
#(
  parameter int N_DOM = 3,
  parameter int LVL_W = $clog2(N_DOM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tgt_lvl_i,
  input  logic [N_DOM-1:0] keep_on_i,
  input  logic [N_DOM-1:0] done_i,
  input  logic             expire_i,
  output logic [N_DOM-1:0] dom_en_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             tmr_clr_o
);
  seq_st_e          st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [LVL_W-1:0] step_q, step_d;
  logic [N_DOM-1:0] en_q, en_d;
  logic             err_q, err_d;
  logic [LVL_W-1:0] dn_idx;

  assign dn_idx = lvl_q - 1'b1;

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    step_d = step_q;
    en_d   = en_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (tgt_lvl_i > lvl_q) begin
          step_d       = lvl_q;
          en_d[lvl_q]  = 1'b1;
          st_d         = ST_UP;
        end else if (tgt_lvl_i < lvl_q) begin
          step_d = dn_idx;
          if (keep_on_i[dn_idx]) begin
            lvl_d = dn_idx;            // skipped, no wait
          end else begin
            en_d[dn_idx] = 1'b0;
            st_d         = ST_DN;
          end
        end
      end
      ST_UP: begin
        if (done_i[step_q]) begin
          lvl_d = step_q + 1'b1;
          st_d  = ST_IDLE;
        end else if (expire_i) begin
          err_d = 1'b1;
          st_d  = ST_FAULT;
        end
      end
      ST_DN: begin
        if (!done_i[step_q]) begin
          lvl_d = step_q;
          st_d  = ST_IDLE;
        end else if (expire_i) begin
          err_d = 1'b1;
          st_d  = ST_FAULT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      step_q <= '0;
      en_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      step_q <= step_d;
      en_q   <= en_d;
      err_q  <= err_d;
    end
  end

  assign dom_en_o  = en_q;
  assign busy_o    = (st_q == ST_UP) || (st_q == ST_DN);
  assign err_o     = err_q;
  assign tmr_clr_o = !busy_o;

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dom_en_o ^ $past(dom_en_o)) <= 1); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
  AST_FAULT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(dom_en_o)); // R9
  AST_FAULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R9
  AST_BUSY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dom_en_o[0]) |-> busy_o); // R7

  for (genvar d = 1; d < N_DOM; d++) begin : g_dep
    AST_DEP_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dom_en_o[d]) |-> $past(dom_en_o[d-1])); // R3
    AST_DONE_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dom_en_o[d]) |-> $past(done_i[d-1])); // R2
  end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int N_DOM   = 3,
  parameter int TMO_CYC = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] cfg_init_i,
  input  logic [N_DOM-1:0] cfg_src_pin_i,
  input  logic [N_DOM-1:0] pin_en_i,
  input  logic [N_DOM-1:0] keep_on_i,
  input  logic             reg_wr_i,
  input  logic [N_DOM-1:0] reg_wdata_i,
  output logic [N_DOM-1:0] reg_rdata_o,
  output logic             rej_o,
  input  logic [N_DOM-1:0] dom_done_i,
  output logic [N_DOM-1:0] dom_en_o,
  output logic             busy_o,
  output logic             err_o
);
  localparam int LVL_W = $clog2(N_DOM + 1);
  localparam int TMO_W = $clog2(TMO_CYC + 1);

  logic [N_DOM-1:0] req;
  logic [LVL_W-1:0] tgt_lvl;
  logic             expire;
  logic             tmr_clr;
  logic             busy;

  pds_enable_regs #(.N_DOM(N_DOM)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_init_i    (cfg_init_i),
    .cfg_src_pin_i (cfg_src_pin_i),
    .pin_en_i      (pin_en_i),
    .wr_i          (reg_wr_i),
    .wdata_i       (reg_wdata_i),
    .busy_i        (busy),
    .req_o         (req),
    .rdata_o       (reg_rdata_o),
    .rej_o         (rej_o)
  );

  pds_target #(.N_DOM(N_DOM), .LVL_W(LVL_W)) u_tgt (
    .req_i     (req),
    .tgt_lvl_o (tgt_lvl)
  );

  pds_timer #(.TMO_CYC(TMO_CYC), .TMO_W(TMO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .expire_o (expire)
  );

  pds_step_fsm #(.N_DOM(N_DOM), .LVL_W(LVL_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tgt_lvl_i (tgt_lvl),
    .keep_on_i (keep_on_i),
    .done_i    (dom_done_i),
    .expire_i  (expire),
    .dom_en_o  (dom_en_o),
    .busy_o    (busy),
    .err_o     (err_o),
    .tmr_clr_o (tmr_clr)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_pwr_domain_seq.sv
module sim_pwr_domain_seq;
  localparam int CLK_PER = 10;
  localparam int DLY     = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cfg_init = 3'b100;
  logic [2:0] cfg_src_pin = 3'b011;
  logic [2:0] pin_en = 3'b000;
  logic [2:0] keep_on = 3'b000;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_wdata = 3'b000;
  logic [2:0] reg_rdata;
  logic       rej;
  logic [2:0] dom_done = 3'b000;
  logic [2:0] dom_en;
  logic       busy;
  logic       err;

  int  errs = 0;
  int  checks = 0;
  bit  ended = 1'b0;
  logic [2:0] exp_q[$];
  logic [2:0] stuck = 3'b000;
  int  rcnt[3] = '{0, 0, 0};

  always #(CLK_PER/2) clk = ~clk;

  pwr_domain_seq u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cfg_init_i    (cfg_init),
    .cfg_src_pin_i (cfg_src_pin),
    .pin_en_i      (pin_en),
    .keep_on_i     (keep_on),
    .reg_wr_i      (reg_wr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .rej_o         (rej),
    .dom_done_i    (dom_done),
    .dom_en_o      (dom_en),
    .busy_o        (busy),
    .err_o         (err)
  );

  // regulator model: done follows enable after DLY cycles
  always @(negedge clk) begin
    for (int d = 0; d < 3; d++) begin
      if (stuck[d] || dom_en[d] == dom_done[d]) rcnt[d] = 0;
      else if (rcnt[d] == DLY) begin
        dom_done[d] = dom_en[d];
        rcnt[d] = 0;
      end else rcnt[d] = rcnt[d] + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_en(input logic [2:0] v);
    exp_q.push_back(v);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R2 sequence drained", exp_q.size(), 0);
    repeat (DLY + 6) @(negedge clk);
  endtask

  // call at a negedge
  task automatic reg_write(input logic [2:0] v, input logic exp_rej,
                           input logic [2:0] exp_rd, input string tag);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    chk({tag, " rej"}, rej, exp_rej);
    chk({tag, " rdata"}, reg_rdata, exp_rd);
    @(negedge clk);
    chk({tag, " rej one cycle"}, rej, 0);
  endtask

  // monitor: every change of dom_en must match the next expected vector
  initial begin
    logic [2:0] prev;
    prev = 3'b000;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (dom_en !== prev) begin
        if (exp_q.size() == 0) chk("R2 unexpected enable change", dom_en, prev);
        else chk("R2/R4 enable order", dom_en, exp_q.pop_front());
        prev = dom_en;
      end
    end
  end

  initial begin
    #(CLK_PER * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog: act=expired exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 dom_en", dom_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 rej", rej, 0);
    chk("R1 rdata", reg_rdata, 3'b100);

    // POWER request alone is held off
    pin_en[1] = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 power held off", dom_en, 0);
    chk("R3 idle", busy, 0);

    // system up; power and power1 follow
    expect_en(3'b001);
    expect_en(3'b011);
    expect_en(3'b111);
    pin_en[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 busy during step", busy, 1);
    drain();
    chk("R2 all up", dom_en, 3'b111);
    chk("R7 busy low when settled", busy, 0);

    // power1 comes from the register, so its pin is ignored
    pin_en[2] = 1'b1;
    repeat (10) @(negedge clk);
    pin_en[2] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 pin ignored for register source", dom_en, 3'b111);

    // accepted write drops power1, a write while busy is rejected
    expect_en(3'b011);
    reg_write(3'b000, 1'b0, 3'b000, "R6 write idle");
    for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
    chk("R7 busy on power-down", busy, 1);
    reg_write(3'b100, 1'b1, 3'b000, "R8 write busy");
    drain();
    chk("R8 dropped write had no effect", dom_en, 3'b011);

    expect_en(3'b111);
    reg_write(3'b100, 1'b0, 3'b100, "R6 write back");
    drain();

    // keep-on POWER skipped during power-down
    keep_on = 3'b010;
    expect_en(3'b011);
    expect_en(3'b010);
    pin_en[0] = 1'b0;
    drain();
    chk("R5 kept domain on", dom_en, 3'b010);
    chk("R4 idle after power-down", busy, 0);

    keep_on = 3'b000;
    expect_en(3'b011);
    expect_en(3'b111);
    pin_en[0] = 1'b1;
    drain();
    chk("R2 back up", dom_en, 3'b111);

    // power1 done stuck high: timeout
    stuck[2] = 1'b1;
    expect_en(3'b011);
    pin_en[0] = 1'b0;
    repeat (100) @(negedge clk);
    chk("R9 no error before timeout", err, 0);
    chk("R9 busy while waiting", busy, 1);
    repeat (200) @(negedge clk);
    chk("R9 error set", err, 1);
    chk("R9 busy dropped", busy, 0);
    chk("R9 enables frozen", dom_en, 3'b011);
    pin_en = 3'b000;
    repeat (20) @(negedge clk);
    chk("R9 no further steps", dom_en, 3'b011);
    chk("R9 error sticky", err, 1);
    chk("R2 no stray changes", exp_q.size(), 0);
    summary();
  end
endmodule